// File: doc/BRIEF.md
# Prioritizing Interrupt Controller with Vector Generation

This block gathers interrupt requests from a set of on-chip peripherals and from three external request pins. It merges them into a single 3-bit priority level for a processor core. When the core acknowledges a level, the block answers with an 8-bit vector number. The core can also learn which peripheral is asking by reading the pending register, without running an acknowledge at all.

The external pins work in one of two modes:
- **Encoded mode:** the three pins carry an active-low encoded level.
- **Dedicated mode:** the pins are three separate active-low requests at levels 7, 6 and 1. Each pin can be made edge- or level-sensitive, and each can have its vector produced inside the block.

All internal peripherals share one level (`INT_LVL`). Among them the order is fixed: a higher source index wins. An in-service register records acknowledged sources so that only a higher-priority source can nest above them.

The acknowledge path uses valid/ready on both sides:
- **Request side:** an acknowledge is accepted on a clock edge where `ack_valid` and `ack_ready` are both high. The response appears on `vec_valid`/`vec_num`/`vec_ext` in the next cycle.
- **Response side:** the response is held stable until `vec_ready` is sampled high. While a response waits, `ack_ready` is low and no new acknowledge is taken.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After `rst_n` is released, all four registers read 0, `ipl` is 0, `vec_valid` is 0 and `ack_ready` is 1.
- R2: The mode register (address 0) has the following layout. Writable bits are 15, 14..12, 10..8 and 7..5; all other bits read as 0 (write mask 0xF7E0).

  | Bits | Meaning |
  |------|---------|
  | 15 | 1 = dedicated mode |
  | 14, 13, 12 | Internal-vector enable for levels 7, 6, 1 |
  | 10, 9, 8 | 1 = edge trigger for levels 7, 6, 1 |
  | 7..5 | Upper vector bits |

- R3: Pending bit i (address 1) sets in any cycle where `int_req[i]` is high. Writing 1 to the bit clears it, but a request in the same cycle wins. The register is readable at any time without an acknowledge.
- R4: A pending source requests only while its mask bit (address 2, read/write) is 1. A masked source still shows in the pending register.
- R5: Any eligible internal source drives `ipl` to `INT_LVL`. The highest eligible index is the one selected.
- R6: In encoded mode, `ipl` is the larger of `~ext_n` and the internal level.
- R7: In dedicated mode with level trigger, a low on `ext_n[2]`, `ext_n[1]` or `ext_n[0]` requests level 7, 6 or 1 respectively. The request is combinational from the pin.
- R8: In dedicated mode with edge trigger, a high-to-low pin change is latched at the clock edge that samples it. The latch holds after the pin returns high, and it is cleared when that level is acknowledged.
- R9: An acknowledge at `INT_LVL` with an eligible source returns `vec_num = {mode[7:5], index}` and `vec_ext = 0`. It also sets that source's in-service bit (address 3).
- R10: A set in-service bit blocks sources of equal or lower index. Writing 1 to an in-service bit clears it.
- R11: In dedicated mode, an acknowledge at level 7, 6 or 1 behaves as follows:
  - With that line's internal-vector enable set, it returns `{mode[7:5], code}` with codes 31, 30 and 29 respectively.
  - Otherwise it returns `vec_ext = 1` and `vec_num = 0`.
  - In encoded mode, an acknowledge at a nonzero level with no internal winner returns `vec_ext = 1` and `vec_num = 0`.
- R12: Any other acknowledge is spurious and returns `{mode[7:5], 24}` with `vec_ext = 0`.
- R13: The response is visible in the cycle after acceptance and holds while `vec_ready` is low. `ack_ready` equals `!vec_valid`.
- R14: A one-cycle `soft_rst` clears pending, mask, in-service and the edge latches, but leaves the mode register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous full reset, active low |
| soft_rst | input | 1 | Synchronous partial reset; mode register kept |
| int_req | input | NSRC | Internal peripheral requests |
| ext_n | input | 3 | External request pins, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 pending, 2 mask, 3 in-service |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| ipl | output | 3 | Priority level presented to the core |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Block can accept an acknowledge |
| ack_level | input | 3 | Level being acknowledged |
| vec_valid | output | 1 | Vector response valid |
| vec_ready | input | 1 | Core takes the response |
| vec_num | output | 8 | Vector number |
| vec_ext | output | 1 | 1 = an external device must supply the vector |

## Verification
Random peripheral request and mask patterns, with a random upper vector field, are acknowledged repeatedly until no source is left. Each returned index must match a bench-computed pick under the accumulated in-service set. These patterns separate index priority order, the mask gating, in-service blocking of equal and lower sources, and the vector composition, and each chain must end in the spurious code.

Directed pin sequences distinguish the three external cases:
- an encoded level above, and below, the internal level;
- a level-triggered dedicated line, which drops as soon as the pin rises;
- an edge-triggered line, which survives the pin rising until its acknowledge.

A held `vec_ready` low separates correct response holding from a lost or overwritten vector. A soft reset with a written mode register separates the two reset domains.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW        = 16;
  localparam int VEC_W     = 8;
  localparam int VEC_LO_W  = 5;
  localparam int VEC_HI_W  = VEC_W - VEC_LO_W;
  localparam int NLINES    = 3;

  localparam logic [DW-1:0] MODE_WMASK = 16'hF7E0;
  localparam int MODE_DED_BIT = 15;
  localparam int IVEN_LSB     = 12;
  localparam int TRIG_LSB     = 8;
  localparam int VHI_LSB      = 5;

  localparam logic [VEC_LO_W-1:0] CODE_SPUR = 5'd24;
  localparam logic [VEC_LO_W-1:0] CODE_L1   = 5'd29;
  localparam logic [VEC_LO_W-1:0] CODE_L6   = 5'd30;
  localparam logic [VEC_LO_W-1:0] CODE_L7   = 5'd31;

  typedef enum logic [1:0] {
    RSP_INT  = 2'd0,
    RSP_LINE = 2'd1,
    RSP_EXT  = 2'd2,
    RSP_SPUR = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_PEND = 2'd1,
    A_MASK = 2'd2,
    A_ISR  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_ext_lines.sv
module irq_ext_lines
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [NLINES-1:0] pin_n,
  input  logic              ded_mode,
  input  logic [NLINES-1:0] edge_sel,
  input  logic [NLINES-1:0] lat_clr,
  output logic [2:0]        ext_lvl
);
  logic [NLINES-1:0] prev_q, lat_q, line_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= pin_n;
  end

  genvar k;
  generate
    for (k = 0; k < NLINES; k++) begin : g_line
      logic fall;
      assign fall = prev_q[k] & ~pin_n[k];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           lat_q[k] <= 1'b0;
        else if (soft_rst)                    lat_q[k] <= 1'b0;
        else if (fall && ded_mode && edge_sel[k]) lat_q[k] <= 1'b1;
        else if (lat_clr[k])                  lat_q[k] <= 1'b0;
      end

      assign line_req[k] = edge_sel[k] ? lat_q[k] : ~pin_n[k];

      assert_edge_latch_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q[k]) |-> ($past(prev_q[k]) && !prev_q[k]));
    end
  endgenerate

  always_comb begin
    if (!ded_mode)        ext_lvl = ~pin_n;
    else if (line_req[2]) ext_lvl = 3'd7;
    else if (line_req[1]) ext_lvl = 3'd6;
    else if (line_req[0]) ext_lvl = 3'd1;
    else                  ext_lvl = 3'd0;
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic [NSRC-1:0]     int_req,
  input  logic                wr_pend,
  input  logic                wr_mask,
  input  logic                wr_isr,
  input  logic [NSRC-1:0]     wdata,
  input  logic                isr_set,
  input  logic [VEC_LO_W-1:0] isr_idx,
  output logic [NSRC-1:0]     pend_q,
  output logic [NSRC-1:0]     mask_q,
  output logic [NSRC-1:0]     isr_q,
  output logic                int_any,
  output logic [VEC_LO_W-1:0] int_idx
);
  logic [NSRC-1:0] cand, set_oh;
  logic            isr_any;
  logic [VEC_LO_W-1:0] isr_top;

  assign cand   = pend_q & mask_q;
  assign set_oh = isr_set ? (NSRC'(1) << isr_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      isr_q  <= '0;
    end else if (soft_rst) begin
      pend_q <= '0;
      mask_q <= '0;
      isr_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~(wr_pend ? wdata : '0)) | int_req;
      if (wr_mask) mask_q <= wdata;
      isr_q  <= (isr_q & ~(wr_isr ? wdata : '0)) | set_oh;
    end
  end

  always_comb begin
    isr_any = 1'b0;
    isr_top = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (isr_q[i]) begin
        isr_any = 1'b1;
        isr_top = VEC_LO_W'(i);
      end
    end
  end

  always_comb begin
    int_any = 1'b0;
    int_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!isr_any || VEC_LO_W'(i) > isr_top)) begin
        int_any = 1'b1;
        int_idx = VEC_LO_W'(i);
      end
    end
  end

  assert_pick_is_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_any |-> ((cand >> int_idx) & NSRC'(1)) != '0);

  assert_isr_grows_by_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_q & ~$past(isr_q)) != '0) |-> $past(isr_set));
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_pkg::*;
#(
  parameter int NSRC    = 16,
  parameter int INT_LVL = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                ded_mode,
  input  logic [NLINES-1:0]   iv_en,
  input  logic [VEC_HI_W-1:0] vhi,
  input  logic                int_any,
  input  logic [VEC_LO_W-1:0] int_idx,
  input  logic                ack_valid,
  input  logic [2:0]          ack_level,
  output logic                ack_ready,
  output logic                vec_valid,
  input  logic                vec_ready,
  output logic [VEC_W-1:0]    vec_num,
  output logic                vec_ext,
  output logic                isr_set,
  output logic [VEC_LO_W-1:0] isr_idx,
  output logic [NLINES-1:0]   lat_clr
);
  logic take, line_hit, use_int;
  logic [1:0] line_sel;
  rsp_kind_e kind_d, kind_q;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic vld_q;

  assign ack_ready = !vld_q;
  assign take      = ack_valid && ack_ready;
  assign use_int   = (ack_level == 3'(INT_LVL)) && int_any;

  always_comb begin
    line_hit = ded_mode;
    line_sel = 2'd0;
    case (ack_level)
      3'd7:    line_sel = 2'd2;
      3'd6:    line_sel = 2'd1;
      3'd1:    line_sel = 2'd0;
      default: line_hit = 1'b0;
    endcase
  end

  always_comb begin
    kind_d = RSP_SPUR;
    vec_d  = {vhi, CODE_SPUR};
    if (use_int) begin
      kind_d = RSP_INT;
      vec_d  = {vhi, int_idx};
    end else if (line_hit) begin
      if (iv_en[line_sel]) begin
        kind_d = RSP_LINE;
        case (line_sel)
          2'd2:    vec_d = {vhi, CODE_L7};
          2'd1:    vec_d = {vhi, CODE_L6};
          default: vec_d = {vhi, CODE_L1};
        endcase
      end else begin
        kind_d = RSP_EXT;
        vec_d  = '0;
      end
    end else if (!ded_mode && ack_level != 3'd0) begin
      kind_d = RSP_EXT;
      vec_d  = '0;
    end
  end

  assign isr_set = take && use_int;
  assign isr_idx = int_idx;
  assign lat_clr = (take && !use_int && line_hit) ? (NLINES'(1) << line_sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      vec_q  <= '0;
      kind_q <= RSP_SPUR;
    end else if (soft_rst) begin
      vld_q  <= 1'b0;
    end else if (take) begin
      vld_q  <= 1'b1;
      vec_q  <= vec_d;
      kind_q <= kind_d;
    end else if (vec_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign vec_valid = vld_q;
  assign vec_num   = vec_q;
  assign vec_ext   = vld_q && (kind_q == RSP_EXT);

  assert_vec_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready && !soft_rst) |=> (vec_valid && $stable(vec_num)));

  assert_int_vec_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && kind_q == RSP_INT) |-> (int'(vec_num[VEC_LO_W-1:0]) < NSRC));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC    = 16,
  parameter int INT_LVL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [NSRC-1:0]   int_req,
  input  logic [2:0]        ext_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [2:0]        ipl,
  input  logic              ack_valid,
  output logic              ack_ready,
  input  logic [2:0]        ack_level,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [7:0]        vec_num,
  output logic              vec_ext
);
  logic [DW-1:0] mode_q;
  logic [NSRC-1:0] pend_q, mask_q, isr_q;
  logic int_any, isr_set;
  logic [VEC_LO_W-1:0] int_idx, isr_idx;
  logic [NLINES-1:0] lat_clr;
  logic [2:0] ext_lvl, int_lvl;
  logic ded_mode;
  reg_addr_e addr;

  assign addr     = reg_addr_e'(reg_addr);
  assign ded_mode = mode_q[MODE_DED_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (reg_we && addr == A_MODE) mode_q <= reg_wdata & MODE_WMASK;
  end

  irq_ext_lines u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .pin_n    (ext_n),
    .ded_mode (ded_mode),
    .edge_sel (mode_q[TRIG_LSB +: NLINES]),
    .lat_clr  (lat_clr),
    .ext_lvl  (ext_lvl)
  );

  irq_src_bank #(.NSRC(NSRC)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .int_req  (int_req),
    .wr_pend  (reg_we && addr == A_PEND),
    .wr_mask  (reg_we && addr == A_MASK),
    .wr_isr   (reg_we && addr == A_ISR),
    .wdata    (reg_wdata[NSRC-1:0]),
    .isr_set  (isr_set),
    .isr_idx  (isr_idx),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .isr_q    (isr_q),
    .int_any  (int_any),
    .int_idx  (int_idx)
  );

  irq_vec_unit #(.NSRC(NSRC), .INT_LVL(INT_LVL)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .ded_mode  (ded_mode),
    .iv_en     (mode_q[IVEN_LSB +: NLINES]),
    .vhi       (mode_q[VHI_LSB +: VEC_HI_W]),
    .int_any   (int_any),
    .int_idx   (int_idx),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .ack_ready (ack_ready),
    .vec_valid (vec_valid),
    .vec_ready (vec_ready),
    .vec_num   (vec_num),
    .vec_ext   (vec_ext),
    .isr_set   (isr_set),
    .isr_idx   (isr_idx),
    .lat_clr   (lat_clr)
  );

  assign int_lvl = int_any ? 3'(INT_LVL) : 3'd0;
  assign ipl     = (ext_lvl > int_lvl) ? ext_lvl : int_lvl;

  always_comb begin
    case (addr)
      A_MODE:  reg_rdata = mode_q;
      A_PEND:  reg_rdata = DW'(pend_q);
      A_MASK:  reg_rdata = DW'(mask_q);
      default: reg_rdata = DW'(isr_q);
    endcase
  end

  assert_mode_survives_soft_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !(reg_we && addr == A_MODE)) |=> $stable(mode_q));
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int NSRC = 16;
  localparam int INT_LVL = 4;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic [NSRC-1:0] int_req = '0;
  logic [2:0] ext_n = 3'b111;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [2:0] ipl, ack_level = 3'd0;
  logic ack_valid = 1'b0, ack_ready, vec_valid, vec_ready = 1'b1, vec_ext;
  logic [7:0] vec_num;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.NSRC(NSRC), .INT_LVL(INT_LVL)) i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .int_req(int_req), .ext_n(ext_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ipl(ipl), .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_level(ack_level),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_num(vec_num), .vec_ext(vec_ext));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int pick(input logic [15:0] p, input logic [15:0] m, input logic [15:0] s);
    int top = -1, r = -1;
    for (int i = 0; i < NSRC; i++) if (s[i]) top = i;
    for (int i = 0; i < NSRC; i++) if (p[i] && m[i] && i > top) r = i;
    return r;
  endfunction

  function automatic logic [7:0] vec_of(input logic [2:0] hi, input int code);
    return {hi, 5'(code)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ack(input logic [2:0] lvl, output logic [7:0] v, output logic e);
    @(negedge clk); ack_valid = 1'b1; ack_level = lvl;
    @(negedge clk); ack_valid = 1'b0;
    v = vec_num; e = vec_ext;
    check("R13 response valid", 16'(vec_valid), 16'd1);
  endtask

  task automatic pulse_req(input logic [15:0] r);
    @(negedge clk); int_req = r;
    @(negedge clk); int_req = '0;
  endtask

  task automatic do_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic [7:0] v;
    logic e;
    int unsigned seed;
    seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); check("R1 register reset", d, 16'h0); end
    check("R1 ipl reset", 16'(ipl), 16'd0);
    check("R1 vec_valid reset", 16'(vec_valid), 16'd0);
    check("R1 ack_ready reset", 16'(ack_ready), 16'd1);

    // R2 mode write mask
    wr(2'd0, 16'hFFFF); rd(2'd0, d); check("R2 mode readback mask", d, 16'hF7E0);

    // R6 encoded mode
    wr(2'd0, 16'h0000);
    @(negedge clk); ext_n = ~3'd5; #1; check("R6 encoded level", 16'(ipl), 16'd5);
    wr(2'd2, 16'h0008); pulse_req(16'h0008);
    #1; check("R6 encoded above internal", 16'(ipl), 16'd5);
    ext_n = ~3'd3; #1; check("R6 internal above encoded", 16'(ipl), 16'd4);
    ext_n = ~3'd5;
    ack(3'd5, v, e); check("R11 encoded ack external", {7'd0, e, v}, 16'h0100);
    ext_n = 3'b111;

    // R3 pending set wins over clear, write-1 clear
    @(negedge clk); int_req = 16'h0010; reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0010;
    @(negedge clk); reg_we = 1'b0; int_req = '0;
    rd(2'd1, d); check("R3 set wins over clear", d, 16'h0018);
    wr(2'd1, 16'h0018); rd(2'd1, d); check("R3 write-1 clear", d, 16'h0000);
    check("R5 ipl idle", 16'(ipl), 16'd0);

    // R4 masked source visible but silent
    wr(2'd2, 16'h0000); pulse_req(16'h0100);
    rd(2'd1, d); check("R4 masked still pending", d, 16'h0100);
    check("R4 masked no request", 16'(ipl), 16'd0);

    // R14 soft reset
    wr(2'd0, 16'h80A0); wr(2'd2, 16'h00FF); do_soft();
    rd(2'd0, d); check("R14 mode kept", d, 16'h80A0);
    rd(2'd1, d); check("R14 pending cleared", d, 16'h0);
    rd(2'd2, d); check("R14 mask cleared", d, 16'h0);

    // R7 dedicated level trigger, line6 and line1
    wr(2'd0, 16'h8000 | 16'h6000 | (16'd5 << 5));
    @(negedge clk); ext_n = 3'b101; #1; check("R7 line6 level", 16'(ipl), 16'd6);
    ext_n = 3'b100; #1; check("R7 line6 over line1", 16'(ipl), 16'd6);
    ext_n = 3'b110; #1; check("R7 line1 level", 16'(ipl), 16'd1);
    ext_n = 3'b111; #1; check("R7 release", 16'(ipl), 16'd0);
    ext_n = 3'b101;
    ack(3'd6, v, e); check("R11 line6 internal vector", {7'd0, e, v}, {8'd0, vec_of(3'd5, 30)});
    ack(3'd1, v, e); check("R11 line1 external", {7'd0, e, v}, 16'h0100);
    ext_n = 3'b111;

    // R8 edge trigger on line7
    wr(2'd0, 16'h8000 | 16'h4000 | 16'h0400 | (16'd6 << 5));
    @(negedge clk); ext_n = 3'b011;
    @(negedge clk); check("R8 edge latched", 16'(ipl), 16'd7);
    ext_n = 3'b111;
    @(negedge clk); check("R8 latch holds", 16'(ipl), 16'd7);
    ack(3'd7, v, e); check("R11 line7 vector", {7'd0, e, v}, {8'd0, vec_of(3'd6, 31)});
    #1; check("R8 latch cleared by ack", 16'(ipl), 16'd0);

    // R13 back-pressure
    wr(2'd2, 16'h0004); pulse_req(16'h0004);
    @(negedge clk); vec_ready = 1'b0; ack_valid = 1'b1; ack_level = 3'd4;
    @(negedge clk); ack_valid = 1'b0;
    v = vec_num;
    check("R9 vector index 2", 16'(v), 16'(vec_of(3'd6, 2)));
    @(negedge clk); @(negedge clk);
    check("R13 held valid", 16'(vec_valid), 16'd1);
    check("R13 held vector", 16'(vec_num), 16'(v));
    check("R13 ack_ready low", 16'(ack_ready), 16'd0);
    vec_ready = 1'b1;
    @(negedge clk); check("R13 released", 16'(vec_valid), 16'd0);
    rd(2'd3, d); check("R9 in-service set", d, 16'h0004);
    ack(3'd4, v, e); check("R12 spurious after block", 16'(v), 16'(vec_of(3'd6, 24)));
    wr(2'd3, 16'h0004); rd(2'd3, d); check("R10 in-service w1c", d, 16'h0);
    check("R10 source presented again", 16'(ipl), 16'd4);

    // Random chains: R5 R9 R10 R12
    for (int it = 0; it < 40; it++) begin
      logic [15:0] rq, mk, sm;
      logic [2:0] hi;
      int p;
      rq = 16'($urandom()); mk = 16'($urandom()); hi = 3'($urandom()); sm = '0;
      do_soft();
      wr(2'd0, 16'h8000 | (16'(hi) << 5));
      wr(2'd2, mk); pulse_req(rq);
      rd(2'd1, d); check("R3 pending polled", d, rq);
      check("R5 ipl internal", 16'(ipl), (pick(rq, mk, sm) >= 0) ? 16'd4 : 16'd0);
      for (int n = 0; n < 17; n++) begin
        p = pick(rq, mk, sm);
        if (p < 0) break;
        ack(3'd4, v, e);
        check("R9 R10 nested vector", {7'd0, e, v}, {8'd0, vec_of(hi, p)});
        sm[p] = 1'b1;
      end
      ack(3'd4, v, e); check("R12 spurious end of chain", {7'd0, e, v}, {8'd0, vec_of(hi, 24)});
      rd(2'd3, d); check("R10 in-service record", d, sm);
    end

    finish_run();
  end
endmodule